// File: doc/BRIEF.md
# Configuration-Frame Upset Injector

This block emulates radiation-induced single-event upsets in a configuration memory that is organised as frames of bits. On each command it draws a pseudo-random frame and bit position, reads that whole frame, inverts exactly the one chosen bit and writes the frame back to the same place. The remaining bits of the frame keep their old values, because one frame write updates every bit it covers. Each injection's position is kept in an internal log that can be read out once the campaign is over.

The upper bits of every frame hold flip-flop state. That state may be read but must never be written, so those bits are never chosen. Static content (logic functions and routing) can be upset while the target keeps running. Dynamic content (memory the target uses) needs the target to be frozen for the whole read-modify-write, or the readback and the write-back could disagree. For such targets the block runs a request/acknowledge handshake before the read and releases it after the write. The frame memory itself sits outside the block, on a simple read/write frame port.

Top module: `cfg_upset_injector`

## Requirements
- R1: The frame written back differs from the frame read in exactly one bit; every other frame in the memory is left unchanged.
- R2: Each injection issues exactly one frame read and one frame write to the same frame address. Read data is taken one cycle after `frm_rd_en`, and the write happens two cycles after the read.
- R3: Positions come from a 16-bit LFSR seeded 16'hACE1 that shifts left, taking as its new bit 0 the XOR of bits 15, 13, 12 and 10. It steps once per drawing cycle. The candidate frame is LFSR bits [3:0] and the candidate bit is bits [8:4]. A candidate with frame ≥ 12 or bit ≥ 24 is rejected and redrawn on the next cycle.
- R4: With `tgt_dyn` low at acceptance, `suspend_req` stays low for the whole injection.
- R5: With `tgt_dyn` high at acceptance, `suspend_req` rises before the read. The read is issued only after `suspend_ack` has been seen high. `suspend_req` stays high through the write and is low again in the cycle after the write.
- R6: Bit positions 24 to 31 of a frame (flip-flop state) are never inverted.
- R7: Every injection appends the 17-bit entry {count[7:0], frame[3:0], bit[4:0]} to a 4-deep log. The count starts at 0 and rises by one per logged injection. `log_dout` shows the oldest entry whenever `log_empty` is low, and a `log_rd_en` pulse removes it.
- R8: While the log is full, a command is refused: no frame access occurs, `busy` stays low and the LFSR does not advance. `overflow` rises and stays high until reset.
- R9: `busy` is high from the cycle after a command is accepted until the cycle in which the log entry is written, and low in the cycle after that. A command that arrives while busy is ignored.
- R10: After reset, `busy`, `suspend_req`, `overflow`, `frm_rd_en` and `frm_wr_en` are low and `log_empty` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inj_cmd | input | 1 | Request one injection |
| tgt_dyn | input | 1 | Target frame holds dynamic content (sampled on acceptance) |
| suspend_ack | input | 1 | Target confirms it is frozen |
| suspend_req | output | 1 | Ask the target to freeze |
| busy | output | 1 | Injection in progress |
| overflow | output | 1 | A command was refused because the log was full (sticky) |
| frm_rd_en | output | 1 | Frame read strobe |
| frm_wr_en | output | 1 | Frame write strobe |
| frm_addr | output | 4 | Frame index for read and write |
| frm_wr_data | output | 32 | Frame contents to write |
| frm_rd_data | input | 32 | Frame contents returned one cycle after a read |
| log_rd_en | input | 1 | Remove the oldest log entry |
| log_empty | output | 1 | Log holds no entries |
| log_full | output | 1 | Log holds 4 entries |
| log_dout | output | 17 | Oldest log entry |

## Verification
The bench runs injections into static and dynamic targets. Static runs show that no suspend handshake occurs. Dynamic runs, with acknowledge delays from 0 to 3 cycles, show that the read waits for the acknowledge and that the release follows the write. Across many random draws, the LFSR rejection sequence produces both accepted and rejected candidates, and a bench model of the generator predicts each frame and bit, which separates a correct redraw from an off-by-one range test or a wrong tap. One directed case sends a second command while the block is busy, and another fills the log and then commands once more. Together they separate "ignored" from "queued" and "refused" from "dropped after drawing". After every injection the bench compares the whole frame memory against its own shadow copy, which catches a flip of the wrong bit as well as damage to a neighbouring frame.

// File: rtl/fi_pkg.sv
package fi_pkg;

  localparam int LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_DRAW  = 3'd1,
    ST_SUSP  = 3'd2,
    ST_READ  = 3'd3,
    ST_WAIT  = 3'd4,
    ST_WRITE = 3'd5,
    ST_LOG   = 3'd6
  } inj_state_e;

  // One step of the position generator: shift left, new bit 0 from taps 15,13,12,10.
  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

endpackage

// File: rtl/fi_lfsr.sv
module fi_lfsr
  import fi_pkg::*;
#(
  parameter int OUT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [OUT_W-1:0] draw
);

  logic [LFSR_W-1:0] state_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    state_q <= LFSR_SEED;
    else if (step) state_q <= lfsr_step(state_q);
  end

  assign draw = state_q[OUT_W-1:0];

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) state_q != '0); // R3

endmodule

// File: rtl/fi_log_fifo.sv
module fi_log_fifo #(
  parameter int DW    = 17,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic          empty,
  output logic          full
);

  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW:0]   wr_ptr_q, rd_ptr_q;

  always_ff @(posedge clk) begin
    if (push) mem_q[wr_ptr_q[AW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (push) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (pop)  rd_ptr_q <= rd_ptr_q + 1'b1;
    end
  end

  assign empty = (wr_ptr_q == rd_ptr_q);
  assign full  = (wr_ptr_q[AW] != rd_ptr_q[AW]) && (wr_ptr_q[AW-1:0] == rd_ptr_q[AW-1:0]);
  assign dout  = mem_q[rd_ptr_q[AW-1:0]];

  AST_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (!rst_n) push |-> !full); // R8
  AST_NO_UNDERRUN:  assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty); // R7

endmodule

// File: rtl/cfg_upset_injector.sv
module cfg_upset_injector
  import fi_pkg::*;
#(
  parameter int N_FRAMES  = 12,
  parameter int FRAME_W   = 32,
  parameter int INJ_BITS  = 24,
  parameter int LOG_DEPTH = 4,
  parameter int CNT_W     = 8,
  localparam int FW       = $clog2(N_FRAMES),
  localparam int BW       = $clog2(FRAME_W),
  localparam int LOG_W    = CNT_W + FW + BW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inj_cmd,
  input  logic               tgt_dyn,
  input  logic               suspend_ack,
  output logic               suspend_req,
  output logic               busy,
  output logic               overflow,
  output logic               frm_rd_en,
  output logic               frm_wr_en,
  output logic [FW-1:0]      frm_addr,
  output logic [FRAME_W-1:0] frm_wr_data,
  input  logic [FRAME_W-1:0] frm_rd_data,
  input  logic               log_rd_en,
  output logic               log_empty,
  output logic               log_full,
  output logic [LOG_W-1:0]   log_dout
);

  // Position fits the frame array and avoids the flip-flop region.
  function automatic logic pos_ok(input logic [FW-1:0] f, input logic [BW-1:0] b);
    return (int'(f) < N_FRAMES) && (int'(b) < INJ_BITS);
  endfunction

  // Invert a single bit of a frame word.
  function automatic logic [FRAME_W-1:0] flip_one(input logic [FRAME_W-1:0] d,
                                                  input logic [BW-1:0]      b);
    return d ^ ({{(FRAME_W-1){1'b0}}, 1'b1} << b);
  endfunction

  inj_state_e         state_q, state_d;
  logic               dyn_q;
  logic [FW-1:0]      frame_q;
  logic [BW-1:0]      bit_q;
  logic [FRAME_W-1:0] rd_buf_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               ovf_q;

  // Named internal events
  logic               accept_w, refuse_w, draw_step_w, cand_ok_w, log_push_w, log_pop_w;
  logic [FW+BW-1:0]   draw_w;
  logic [FW-1:0]      cand_frame_w;
  logic [BW-1:0]      cand_bit_w;

  fi_lfsr #(.OUT_W(FW + BW)) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (draw_step_w),
    .draw  (draw_w)
  );

  assign cand_frame_w = draw_w[FW-1:0];
  assign cand_bit_w   = draw_w[FW+BW-1:FW];

  assign accept_w    = (state_q == ST_IDLE) && inj_cmd && !log_full;
  assign refuse_w    = (state_q == ST_IDLE) && inj_cmd &&  log_full;
  assign draw_step_w = (state_q == ST_DRAW);
  assign cand_ok_w   = draw_step_w && pos_ok(cand_frame_w, cand_bit_w);
  assign log_push_w  = (state_q == ST_LOG);
  assign log_pop_w   = log_rd_en && !log_empty;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept_w) state_d = ST_DRAW;
      ST_DRAW:  if (cand_ok_w) state_d = dyn_q ? ST_SUSP : ST_READ;
      ST_SUSP:  if (suspend_ack) state_d = ST_READ;
      ST_READ:  state_d = ST_WAIT;
      ST_WAIT:  state_d = ST_WRITE;
      ST_WRITE: state_d = ST_LOG;
      ST_LOG:   state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      dyn_q    <= 1'b0;
      frame_q  <= '0;
      bit_q    <= '0;
      rd_buf_q <= '0;
      cnt_q    <= '0;
      ovf_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept_w)              dyn_q    <= tgt_dyn;
      if (cand_ok_w) begin
        frame_q <= cand_frame_w;
        bit_q   <= cand_bit_w;
      end
      if (state_q == ST_WAIT)    rd_buf_q <= frm_rd_data;
      if (log_push_w)            cnt_q    <= cnt_q + 1'b1;
      if (refuse_w)              ovf_q    <= 1'b1;
    end
  end

  assign busy        = (state_q != ST_IDLE);
  assign overflow    = ovf_q;
  assign frm_rd_en   = (state_q == ST_READ);
  assign frm_wr_en   = (state_q == ST_WRITE);
  assign frm_addr    = frame_q;
  assign frm_wr_data = flip_one(rd_buf_q, bit_q);
  assign suspend_req = dyn_q && ((state_q == ST_SUSP) || (state_q == ST_READ) ||
                                 (state_q == ST_WAIT) || (state_q == ST_WRITE));

  fi_log_fifo #(.DW(LOG_W), .DEPTH(LOG_DEPTH)) u_log (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (log_push_w),
    .din   ({cnt_q, frame_q, bit_q}),
    .pop   (log_pop_w),
    .dout  (log_dout),
    .empty (log_empty),
    .full  (log_full)
  );

  AST_ONE_BIT_FLIP:      assert property (@(posedge clk) disable iff (!rst_n) frm_wr_en |-> $countones(frm_wr_data ^ $past(frm_rd_data)) == 1); // R1
  AST_WR_FOLLOWS_RD:     assert property (@(posedge clk) disable iff (!rst_n) frm_wr_en |-> $past(frm_rd_en, 2) && (frm_addr == $past(frm_addr, 2))); // R2
  AST_STATIC_NO_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n) (busy && !dyn_q) |-> !suspend_req); // R4
  AST_DYN_HELD:          assert property (@(posedge clk) disable iff (!rst_n) ((frm_rd_en || frm_wr_en) && dyn_q) |-> suspend_req); // R5
  AST_RD_AFTER_ACK:      assert property (@(posedge clk) disable iff (!rst_n) (frm_rd_en && dyn_q) |-> $past(suspend_ack)); // R5
  AST_NO_FF_BITS:        assert property (@(posedge clk) disable iff (!rst_n) frm_rd_en |-> (int'(bit_q) < INJ_BITS) && (int'(frame_q) < N_FRAMES)); // R6
  AST_REFUSE_FULL:       assert property (@(posedge clk) disable iff (!rst_n) (!busy && inj_cmd && log_full) |=> !busy && overflow); // R8
  AST_LOG_ENDS_BUSY:     assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> $past(log_push_w)); // R9

endmodule

// File: tb/cfg_upset_injector_bench.sv
module cfg_upset_injector_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NF   = 12;
  localparam int FWD  = 32;
  localparam int INJ  = 24;
  localparam int DEP  = 4;
  localparam int WD_CYCLES = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inj_cmd = 1'b0, tgt_dyn = 1'b0, suspend_ack = 1'b0, log_rd_en = 1'b0;
  logic        suspend_req, busy, overflow, frm_rd_en, frm_wr_en, log_empty, log_full;
  logic [3:0]  frm_addr;
  logic [31:0] frm_wr_data, frm_rd_data;
  logic [16:0] log_dout;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_upset_injector u_cfg_upset_injector (
    .clk(clk), .rst_n(rst_n), .inj_cmd(inj_cmd), .tgt_dyn(tgt_dyn),
    .suspend_ack(suspend_ack), .suspend_req(suspend_req), .busy(busy),
    .overflow(overflow), .frm_rd_en(frm_rd_en), .frm_wr_en(frm_wr_en),
    .frm_addr(frm_addr), .frm_wr_data(frm_wr_data), .frm_rd_data(frm_rd_data),
    .log_rd_en(log_rd_en), .log_empty(log_empty), .log_full(log_full),
    .log_dout(log_dout)
  );

  function automatic logic [31:0] init_word(input int i);
    return 32'h5A5A0F0F ^ (i * 32'h9E3779B9);
  endfunction

  // Behavioural frame memory: read data registered, one cycle latency.
  logic [31:0] mem [NF];
  logic [31:0] rd_q;
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NF; i++) mem[i] <= init_word(i);
      rd_q <= '0;
    end else begin
      if (frm_rd_en && frm_addr < NF) rd_q <= mem[frm_addr];
      if (frm_wr_en && frm_addr < NF) mem[frm_addr] <= frm_wr_data;
    end
  end
  assign frm_rd_data = rd_q;

  int n_cmp = 0, n_bad = 0;
  logic [31:0] shadow [NF];
  logic [15:0] gen = 16'hACE1;
  int exp_cnt = 0;
  logic [16:0] exp_log [$];

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Independent model of the position generator with redraw on out-of-range.
  task automatic model_draw(output int f, output int b);
    logic [15:0] c;
    forever begin
      c = gen;
      gen = (gen << 1) | 16'(^(gen & 16'hB400));
      f = int'(c & 16'h000F);
      b = int'((c >> 4) & 16'h001F);
      if (f < NF && b < INJ) break;
    end
  endtask

  task automatic do_inject(input bit dyn, input bit poke);
    int ef, eb, cyc, rd_n, wr_n, rd_cyc, wr_cyc, ack_wait, ack_dly;
    logic [3:0] rd_a, wr_a;
    logic [31:0] wr_d;
    bit bad_static, bad_dyn, bad_release;
    model_draw(ef, eb);
    ack_dly = int'($urandom % 4);
    rd_n = 0; wr_n = 0; rd_cyc = -1; wr_cyc = -1; ack_wait = 0;
    rd_a = '0; wr_a = '0; wr_d = '0;
    bad_static = 0; bad_dyn = 0; bad_release = 0;
    @(negedge clk); inj_cmd = 1'b1; tgt_dyn = dyn;
    @(negedge clk); inj_cmd = 1'b0;
    chk("R9", "busy after accept", busy, 1);
    cyc = 0;
    while (busy && cyc < 300) begin
      if (frm_rd_en) begin
        rd_n++; rd_cyc = cyc; rd_a = frm_addr;
        if (dyn && !(suspend_req && suspend_ack)) bad_dyn = 1;
      end
      if (frm_wr_en) begin
        wr_n++; wr_cyc = cyc; wr_a = frm_addr; wr_d = frm_wr_data;
        if (dyn && !suspend_req) bad_dyn = 1;
      end
      if (!dyn && suspend_req) bad_static = 1;
      if (wr_cyc >= 0 && cyc == wr_cyc + 1 && suspend_req) bad_release = 1;
      if (suspend_req) begin
        ack_wait++;
        if (ack_wait > ack_dly) suspend_ack = 1'b1;
      end else begin
        ack_wait = 0; suspend_ack = 1'b0;
      end
      if (poke && cyc == 1) inj_cmd = 1'b1;
      if (poke && cyc == 2) inj_cmd = 1'b0;
      @(negedge clk); cyc++;
    end
    suspend_ack = 1'b0;
    chk("R2", "read count", rd_n, 1);
    chk("R2", "write count", wr_n, 1);
    chk("R2", "read-to-write distance", wr_cyc - rd_cyc, 2);
    chk("R3", "read frame", rd_a, ef);
    chk("R2", "write frame", wr_a, ef);
    chk("R1", "written frame", wr_d, shadow[ef] ^ (32'd1 << eb));
    chk("R6", "bit below flip-flop region", eb < INJ, 1);
    chk("R4", "no suspend on static", bad_static, 0);
    chk("R5", "suspend around read/write", bad_dyn, 0);
    chk("R5", "release after write", bad_release, 0);
    shadow[ef] = shadow[ef] ^ (32'd1 << eb);
    for (int i = 0; i < NF; i++) chk("R1", "frame contents", mem[i], shadow[i]);
    @(negedge clk);
    chk("R9", "busy low after log", busy, 0);
    exp_log.push_back({8'(exp_cnt), 4'(ef), 5'(eb)});
    exp_cnt++;
  endtask

  task automatic drain();
    while (exp_log.size() > 0) begin
      logic [16:0] e;
      e = exp_log.pop_front();
      chk("R7", "log not empty", log_empty, 0);
      chk("R7", "log entry", log_dout, e);
      log_rd_en = 1'b1;
      @(negedge clk); log_rd_en = 1'b0;
    end
    chk("R7", "log empty after drain", log_empty, 1);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_bad++;
    $display("FAIL R9 watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NF; i++) shadow[i] = init_word(i);
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", "busy", busy, 0);
    chk("R10", "suspend_req", suspend_req, 0);
    chk("R10", "overflow", overflow, 0);
    chk("R10", "frame strobes", {frm_rd_en, frm_wr_en}, 0);
    chk("R10", "log_empty", log_empty, 1);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed: static, dynamic, static with a command while busy (R9 ignore).
    do_inject(1'b0, 1'b0);
    do_inject(1'b1, 1'b0);
    do_inject(1'b0, 1'b1);
    chk("R9", "no second injection from busy command", busy, 0);
    drain();

    // Fill the log, then a refused command (R8).
    for (int k = 0; k < DEP; k++) do_inject(1'($urandom % 2), 1'b0);
    chk("R8", "log full", log_full, 1);
    @(negedge clk); inj_cmd = 1'b1; tgt_dyn = 1'b0;
    @(negedge clk); inj_cmd = 1'b0;
    for (int k = 0; k < 5; k++) begin
      chk("R8", "refused: busy", busy, 0);
      chk("R8", "refused: no frame access", {frm_rd_en, frm_wr_en}, 0);
      @(negedge clk);
    end
    chk("R8", "overflow raised", overflow, 1);
    drain();

    // More random injections; LFSR must not have advanced on the refusal.
    for (int k = 0; k < 3; k++) do_inject(1'($urandom % 2), 1'($urandom % 2));
    chk("R8", "overflow sticky", overflow, 1);
    drain();

    summary();
    $finish;
  end

endmodule